// File: doc/BRIEF.md
# Programmable Priority Bus Arbiter

This block picks one of eight bus masters per clock to own the bus. Every master carries a 3-bit urgency level, where 0 is the most urgent and 7 the least. The level of a master comes either from a software-written priority register or from a constant fixed at build time. A per-master bit in a separate enable register chooses between the two.

A small register port writes and reads both registers. A write to the priority register is first used by the arbitration decision on the clock after the write. The grant is a registered one-hot vector. The granted master keeps the bus for as long as it holds its request. When it drops the request, the lowest effective level among the current requesters wins, and a tie goes to the lower master index.

Top module: `prio_arbiter`

## Requirements
- R1: During and after reset, `gnt_o` is 0, the enable register reads 0, and the priority register reads 0x1111_1110 (master 0 at level 0, masters 1 to 7 at level 1).
- R2: The priority register gives master i bits [4i+2:4i] for its level. Bit 4i+3 is reserved and always reads 0, whatever value was written to it.
- R3: `reg_sel_i`=0 addresses the priority register and `reg_sel_i`=1 addresses the enable register. The enable register holds `reg_wdata_i[7:0]`, and bits [31:8] read back as 0. Reads are combinational on `reg_rdata_o` for the selected register.
- R4: When enable bit i is 1, master i uses its software level. When the bit is 0, it uses the hardwired level `HW_LVL[3i+2:3i]`. The default hardwired levels for masters 0 to 7 are 7,2,1,3,4,5,6,6.
- R5: When no grant is held, the requester with the numerically lowest effective level is granted. Among equal levels, the lower index wins.
- R6: `gnt_o` has at most one bit set. If no request is present at a clock edge, `gnt_o` is 0 after that edge.
- R7: While the granted master keeps its request high, `gnt_o` does not change, even if a more urgent master starts to request.
- R8: A priority write sampled at clock edge k has no effect on the decision made at edge k. It governs every decision from edge k+1 on.
- R9: A grant bit is only set for a master whose request was high at the edge that produced it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 8 | Request, one bit per master |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | 0 = priority register, 1 = enable register |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data of the selected register |
| gnt_o | output | 8 | One-hot grant, registered |

## Verification
A grant follows the requests and registers sampled at one edge and is visible straight after that edge. A register write is visible on `reg_rdata_o` straight after its edge, but it reaches the grant only on the next edge. The bench drives all inputs 1 ns after a rising edge. A reference model computes the next grant and register contents from the inputs of the same cycle. The bench compares that model with the outputs 1 ns after the following rising edge, so each result is checked exactly one edge after its stimulus. The latency test places a write in the same cycle as competing requests, then checks the old order at that edge and the new order on a later decision.

// File: rtl/prio_arb_pkg.sv
package prio_arb_pkg;
  localparam int unsigned NUM_M_DEF = 8;
  localparam int unsigned LVL_W_DEF = 3;
  localparam logic [NUM_M_DEF*LVL_W_DEF-1:0] HW_LVL_DEF =
    {3'd6, 3'd6, 3'd5, 3'd4, 3'd3, 3'd1, 3'd2, 3'd7};
endpackage

// File: rtl/prio_arb_regs.sv
module prio_arb_regs #(
  parameter int unsigned NUM_M = 8,
  parameter int unsigned LVL_W = 3,
  localparam int unsigned FLD_W = LVL_W + 1,
  localparam int unsigned REG_W = NUM_M * FLD_W
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   we_i,
  input  logic                   sel_i,
  input  logic [REG_W-1:0]       wdata_i,
  output logic [REG_W-1:0]       rdata_o,
  output logic [NUM_M*LVL_W-1:0] sw_lvl_o,
  output logic [NUM_M-1:0]       sw_en_o
);
  logic [NUM_M-1:0] en_q;
  logic [REG_W-1:0] prio_rd;

  for (genvar i = 0; i < NUM_M; i++) begin : g_lvl
    logic [LVL_W-1:0] lvl_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)             lvl_q <= (i == 0) ? LVL_W'(0) : LVL_W'(1);
      else if (we_i && !sel_i) lvl_q <= wdata_i[i*FLD_W +: LVL_W];
    end
    assign sw_lvl_o[i*LVL_W +: LVL_W] = lvl_q;
    // reserved top bit of each field is tied low
    assign prio_rd[i*FLD_W +: FLD_W]  = {1'b0, lvl_q};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            en_q <= '0;
    else if (we_i && sel_i) en_q <= wdata_i[NUM_M-1:0];
  end

  assign sw_en_o = en_q;
  assign rdata_o = sel_i ? REG_W'(en_q) : prio_rd;
endmodule

// File: rtl/prio_arb_lvl_sel.sv
module prio_arb_lvl_sel #(
  parameter int unsigned NUM_M = 8,
  parameter int unsigned LVL_W = 3,
  parameter logic [NUM_M*LVL_W-1:0] HW_LVL = '0
) (
  input  logic [NUM_M*LVL_W-1:0] sw_lvl_i,
  input  logic [NUM_M-1:0]       sw_en_i,
  output logic [NUM_M*LVL_W-1:0] eff_lvl_o
);
  for (genvar i = 0; i < NUM_M; i++) begin : g_sel
    assign eff_lvl_o[i*LVL_W +: LVL_W] =
      sw_en_i[i] ? sw_lvl_i[i*LVL_W +: LVL_W] : HW_LVL[i*LVL_W +: LVL_W];
  end
endmodule

// File: rtl/prio_arb_pick.sv
module prio_arb_pick #(
  parameter int unsigned NUM_M = 8,
  parameter int unsigned LVL_W = 3
) (
  input  logic [NUM_M-1:0]       req_i,
  input  logic [NUM_M*LVL_W-1:0] lvl_i,
  output logic [NUM_M-1:0]       win_o
);
  logic             found;
  logic [LVL_W-1:0] best;

  // strict less-than keeps the lower index on a tie
  always_comb begin
    found = 1'b0;
    best  = '0;
    win_o = '0;
    for (int i = 0; i < NUM_M; i++) begin
      if (req_i[i] && (!found || lvl_i[i*LVL_W +: LVL_W] < best)) begin
        found    = 1'b1;
        best     = lvl_i[i*LVL_W +: LVL_W];
        win_o    = '0;
        win_o[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/prio_arbiter.sv
module prio_arbiter #(
  parameter int unsigned NUM_M = prio_arb_pkg::NUM_M_DEF,
  parameter int unsigned LVL_W = prio_arb_pkg::LVL_W_DEF,
  parameter logic [NUM_M*LVL_W-1:0] HW_LVL = prio_arb_pkg::HW_LVL_DEF,
  localparam int unsigned REG_W = NUM_M * (LVL_W + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NUM_M-1:0] req_i,
  input  logic             reg_we_i,
  input  logic             reg_sel_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  output logic [NUM_M-1:0] gnt_o
);
  logic [NUM_M*LVL_W-1:0] sw_lvl, eff_lvl;
  logic [NUM_M-1:0]       sw_en, win, gnt_q;
  logic                   hold;

  prio_arb_regs #(.NUM_M(NUM_M), .LVL_W(LVL_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (reg_we_i),
    .sel_i    (reg_sel_i),
    .wdata_i  (reg_wdata_i),
    .rdata_o  (reg_rdata_o),
    .sw_lvl_o (sw_lvl),
    .sw_en_o  (sw_en)
  );

  prio_arb_lvl_sel #(.NUM_M(NUM_M), .LVL_W(LVL_W), .HW_LVL(HW_LVL)) u_sel (
    .sw_lvl_i  (sw_lvl),
    .sw_en_i   (sw_en),
    .eff_lvl_o (eff_lvl)
  );

  prio_arb_pick #(.NUM_M(NUM_M), .LVL_W(LVL_W)) u_pick (
    .req_i (req_i),
    .lvl_i (eff_lvl),
    .win_o (win)
  );

  assign hold = |(gnt_q & req_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    gnt_q <= '0;
    else if (!hold) gnt_q <= win;
  end

  assign gnt_o = gnt_q;
endmodule

// File: rtl/prio_arbiter_chk.sv
module prio_arbiter_chk #(
  parameter int unsigned NUM_M = 8,
  parameter int unsigned LVL_W = 3,
  localparam int unsigned FLD_W = LVL_W + 1,
  localparam int unsigned REG_W = NUM_M * FLD_W
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [NUM_M-1:0] req_i,
  input logic             reg_we_i,
  input logic             reg_sel_i,
  input logic [REG_W-1:0] reg_wdata_i,
  input logic [REG_W-1:0] reg_rdata_o,
  input logic [NUM_M-1:0] gnt_o
);
  function automatic logic [REG_W-1:0] rsvd_mask();
    logic [REG_W-1:0] m;
    m = '0;
    for (int i = 0; i < NUM_M; i++) m[i*FLD_W + LVL_W] = 1'b1;
    return m;
  endfunction
  localparam logic [REG_W-1:0] RSVD = rsvd_mask();

  assert_gnt_onehot_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));

  assert_idle_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|req_i) |=> gnt_o == '0);

  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(gnt_o & req_i)) |=> gnt_o == $past(gnt_o));

  assert_gnt_req_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> (gnt_o & ~$past(req_i)) == '0);

  assert_rsvd_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_sel_i |-> (reg_rdata_o & RSVD) == '0);

  assert_wr_visible_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && !reg_sel_i) |=>
      (reg_sel_i || reg_rdata_o == ($past(reg_wdata_i) & ~RSVD)));
endmodule

bind prio_arbiter prio_arbiter_chk #(.NUM_M(NUM_M), .LVL_W(LVL_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .reg_we_i    (reg_we_i),
  .reg_sel_i   (reg_sel_i),
  .reg_wdata_i (reg_wdata_i),
  .reg_rdata_o (reg_rdata_o),
  .gnt_o       (gnt_o)
);

// File: tb/prio_arbiter_tb.sv
module prio_arbiter_tb;
  localparam logic [23:0] HW = {3'd6, 3'd6, 3'd5, 3'd4, 3'd3, 3'd1, 3'd2, 3'd7};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  req = '0;
  logic        we = 1'b0;
  logic        sel = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [7:0]  gnt;

  logic [31:0] m_prio = 32'h1111_1110;
  logic [7:0]  m_en = '0;
  logic [7:0]  m_gnt = '0;
  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  prio_arbiter u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .reg_we_i(we),
    .reg_sel_i(sel), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .gnt_o(gnt)
  );

  function automatic logic [7:0] f_win(logic [7:0] r, logic [31:0] p, logic [7:0] e);
    logic [7:0] w;
    int best;
    w = '0;
    best = 8;
    for (int i = 0; i < 8; i++) begin
      int l;
      l = e[i] ? int'(p[4*i +: 3]) : int'(HW[3*i +: 3]);
      if (r[i] && l < best) begin
        best = l;
        w = 8'(1) << i;
      end
    end
    return w;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic cycle(string tag);
    logic [31:0] np;
    logic [7:0]  ne, ng;
    ng = (|(m_gnt & req)) ? m_gnt : f_win(req, m_prio, m_en);
    np = (we && !sel) ? (wdata & 32'h7777_7777) : m_prio;
    ne = (we && sel) ? wdata[7:0] : m_en;
    @(posedge clk); #1;
    m_prio = np; m_en = ne; m_gnt = ng;
    chk({tag, " gnt"}, 32'(gnt), 32'(m_gnt));
    chk({tag, " rdata"}, rdata, sel ? 32'(m_en) : m_prio);
  endtask

  task automatic wr(logic s, logic [31:0] d, string tag);
    we = 1'b1; sel = s; wdata = d;
    cycle(tag);
    we = 1'b0;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog act=running exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    #12;
    chk("R1 gnt", 32'(gnt), 32'h0);
    chk("R1 prio", rdata, 32'h1111_1110);
    sel = 1'b1; #1;
    chk("R1 en", rdata, 32'h0);
    sel = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;

    // hardwired levels, enable all clear
    req = 8'hFF; cycle("R4");
    chk("R4 lvl1 m2", 32'(gnt), 32'h04);
    req = 8'h00; cycle("R6");
    chk("R6 idle", 32'(gnt), 32'h0);
    req = 8'h81; cycle("R4");
    chk("R4 m7 over m0", 32'(gnt), 32'h80);
    req = 8'h00; cycle("R6");

    // software levels, reset contents
    wr(1'b1, 32'h0000_00FF, "R3");
    req = 8'hF0; cycle("R5");
    chk("R5 tie m4", 32'(gnt), 32'h10);
    req = 8'h00; cycle("R6");
    req = 8'h0E; cycle("R5");
    chk("R5 tie m1", 32'(gnt), 32'h02);
    req = 8'h03; cycle("R7");
    chk("R7 hold m1", 32'(gnt), 32'h02);
    req = 8'h01; cycle("R9");
    chk("R9 m0", 32'(gnt), 32'h01);
    req = 8'h00; cycle("R6");

    // reserved bits
    wr(1'b0, 32'hFFFF_FFFF, "R2");
    chk("R2 rsvd", rdata, 32'h7777_7777);

    // write latency: write and competing requests in one cycle
    req = 8'h21; wr(1'b0, 32'h7707_7777, "R8");
    chk("R8 old order", 32'(gnt), 32'h01);
    req = 8'h00; cycle("R8");
    req = 8'h21; cycle("R8");
    chk("R8 new order", 32'(gnt), 32'h20);
    req = 8'h00; cycle("R6");

    // mixed enable mask
    wr(1'b1, 32'hABCD_EF0A, "R3");
    chk("R3 en read", rdata, 32'h0000_000A);
    req = 8'h0F; cycle("R4");
    chk("R4 mixed m2", 32'(gnt), 32'h04);
    req = 8'h00; cycle("R6");

    // random traffic
    for (int n = 0; n < 400; n++) begin
      req = 8'($urandom) & 8'($urandom);
      we = ($urandom % 4) == 0;
      sel = 1'($urandom);
      wdata = $urandom;
      cycle("R5");
    end
    we = 1'b0; req = '0;
    cycle("R6");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule